// File: doc/BRIEF.md
# Word-to-narrow bus width bridge

This block lets a 32-bit bus master reach two narrower memory-style slaves: one with an 8-bit data path and one with a 16-bit data path. The master runs classic single read and write cycles: it asserts cycle and strobe and waits for a one-clock acknowledge or error. The bridge chooses the downstream port from the upper address bits. It then cuts the 32-bit access into as many narrow slave cycles as the enabled byte lanes need. Write data is spread out across those cycles, and read data is gathered back into one 32-bit word.

Only enabled byte lanes cost slave cycles. A single-byte access on the byte-wide port is one slave cycle. A full word is four cycles on that port and two on the 16-bit port. Each narrow cycle holds its strobe until the slave acknowledges it. The strobe then drops for at least one clock before the next cycle starts.

Some requests cannot be served: an unmapped address, an empty byte-select, or a select pattern on the 16-bit port that crosses the middle of the word. These end at once with a one-clock error and touch no slave.

Top module: `bus_narrow_bridge`

## Requirements
- R1: Region decode uses the address bits in parameter RMASK (default bits 31:28). A match with 0x6000_0000 selects the 8-bit port. A match with 0xA000_0000 selects the 16-bit port. Any other region ends the master cycle with an error and starts no slave cycle. Only one port's cycle signal is ever high at a time.
- R2: On the 8-bit port, each enabled byte lane k (select bit k, data bits 8k+7:8k) gets one slave cycle at slave address {m_adr[SAW-1:2], k}. The cycles run in ascending k. A full-word write followed by a full-word read of the same address returns the written word.
- R3: On the 16-bit port, each half h (h=0 for lanes 1:0, h=1 for lanes 3:2) with any lane enabled gets one slave cycle. That cycle uses slave address {0, m_adr[SAW-2:2], h} and p16_sel equal to the two select bits of that half. Half 0 goes first. A full word round-trips intact.
- R4: A single-lane select (0001, 0010, 0100, 1000) costs exactly one slave cycle on either port. It updates only that byte; the other three bytes of the word read back unchanged.
- R5: The half-word selects 0011 and 1100 are legal on both ports. They move only the low or the high 16 bits of the word.
- R6: On the 16-bit port, a select with lanes 1 and 2 both set but not all four set (0110, 0111, 1110) crosses the half boundary. It is rejected with an error and starts no slave cycle. On the 8-bit port the same patterns are legal and cost one cycle per set lane.
- R7: A select of 0000 is rejected with an error and starts no slave cycle.
- R8: Exactly one of ack or err ends each master cycle, and it is high for exactly one clock. Ack comes only after the last required slave cycle has been acknowledged. m_rdat holds steady while ack is high and carries the gathered bytes in their enabled lanes.
- R9: A synchronous active-high reset clears all slave cycle and strobe outputs and the master ack and err. This state is visible in the cycle after reset is released.
- R10: A slave strobe stays high until that port's ack. It is low in the clock that follows an acknowledged slave cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | 1 | Master cycle valid |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | AW | Master byte address |
| m_sel | input | 4 | Master byte-lane selects |
| m_wdat | input | 32 | Master write data |
| m_rdat | output | 32 | Gathered read data |
| m_ack | output | 1 | One-clock completion |
| m_err | output | 1 | One-clock rejection |
| p8_cyc | output | 1 | 8-bit port cycle |
| p8_stb | output | 1 | 8-bit port strobe |
| p8_we | output | 1 | 8-bit port write enable |
| p8_adr | output | SAW | 8-bit port byte address |
| p8_wdat | output | 8 | 8-bit port write data |
| p8_rdat | input | 8 | 8-bit port read data |
| p8_ack | input | 1 | 8-bit port acknowledge |
| p16_cyc | output | 1 | 16-bit port cycle |
| p16_stb | output | 1 | 16-bit port strobe |
| p16_we | output | 1 | 16-bit port write enable |
| p16_adr | output | SAW | 16-bit port half-word address |
| p16_sel | output | 2 | 16-bit port byte selects |
| p16_wdat | output | 16 | 16-bit port write data |
| p16_rdat | input | 16 | 16-bit port read data |
| p16_ack | input | 1 | 16-bit port acknowledge |

## Verification
A wrong pending-lane mask shows up as soon as the transfer runs, at the slave ports: a slave cycle is missing, extra or out of order, with the wrong address or the wrong p16_sel. The bench compares the logged slave cycles of every transfer against a list it builds from the address and select. A wrong lane index in gathering or spreading data corrupts a byte that the next full-word read exposes, because the bench keeps its own byte-level copy of both memories. A stuck sequencer state shows as a missing, doubled or wrong response within a few clocks, and the per-clock monitor flags strobes that do not drop after an acknowledge.

// File: rtl/bnb_pkg.sv
package bnb_pkg;

  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_B8   = 2'd1,
    PORT_B16  = 2'd2
  } port_e;

  // lowest pending unit gets served first
  function automatic logic [1:0] first_unit(input logic [3:0] m);
    if (m[0])      return 2'd0;
    else if (m[1]) return 2'd1;
    else if (m[2]) return 2'd2;
    else           return 2'd3;
  endfunction

endpackage

// File: rtl/bnb_decode.sv
module bnb_decode
  import bnb_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [AW-1:0] RMASK    = 32'hF000_0000,
  parameter logic [AW-1:0] B8_BASE  = 32'h6000_0000,
  parameter logic [AW-1:0] B16_BASE = 32'hA000_0000
) (
  input  logic [AW-1:0] adr,
  input  logic [3:0]    sel,
  output port_e         kind,
  output logic          ok,
  output logic [3:0]    units
);

  logic crosses_half;

  always_comb begin
    if ((adr & RMASK) == B8_BASE)       kind = PORT_B8;
    else if ((adr & RMASK) == B16_BASE) kind = PORT_B16;
    else                                kind = PORT_NONE;

    crosses_half = sel[1] & sel[2] & ~(sel[0] & sel[3]);
    ok = (kind != PORT_NONE) && (sel != 4'b0000) &&
         !((kind == PORT_B16) && crosses_half);

    // one unit per byte on the narrow port, one per half on the wide one
    units = (kind == PORT_B16) ? {2'b00, |sel[3:2], |sel[1:0]} : sel;
  end

endmodule

// File: rtl/bnb_seq.sv
module bnb_seq
  import bnb_pkg::*;
#(
  parameter int SAW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic           req_we,
  input  logic [SAW-1:0] req_adr,
  input  logic [3:0]     req_sel,
  input  logic [31:0]    req_wdat,
  input  port_e          req_kind,
  input  logic           req_ok,
  input  logic [3:0]     req_units,
  output logic [31:0]    rdat,
  output logic           ack,
  output logic           err,
  output logic           cyc8,
  output logic           stb8,
  output logic           cyc16,
  output logic           stb16,
  output logic           s_we,
  output logic [SAW-1:0] s_adr,
  output logic [1:0]     s_sel,
  output logic [15:0]    s_wdat,
  input  logic [7:0]     p8_rdat,
  input  logic           p8_ack,
  input  logic [15:0]    p16_rdat,
  input  logic           p16_ack
);

  localparam int BW = SAW - 2;

  typedef enum logic {S_IDLE, S_RUN} st_e;

  st_e            st;
  port_e          kind_q;
  logic [31:0]    wdat_q;
  logic [3:0]     sel_q;
  logic [BW-1:0]  base_q;
  logic [3:0]     pend;
  logic [1:0]     cur;
  logic [1:0]     nxt;
  logic           s_ack;
  logic [4:0]     nxt_bofs, cur_bofs, nxt_hofs, cur_hofs;

  assign nxt      = first_unit(pend);
  assign nxt_bofs = {nxt, 3'b000};
  assign cur_bofs = {cur, 3'b000};
  assign nxt_hofs = {nxt[0], 4'b0000};
  assign cur_hofs = {cur[0], 4'b0000};
  assign s_ack    = (kind_q == PORT_B8) ? p8_ack : p16_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      kind_q <= PORT_NONE;
      wdat_q <= '0;
      sel_q  <= '0;
      base_q <= '0;
      pend   <= '0;
      cur    <= '0;
      rdat   <= '0;
      ack    <= 1'b0;
      err    <= 1'b0;
      cyc8   <= 1'b0;
      stb8   <= 1'b0;
      cyc16  <= 1'b0;
      stb16  <= 1'b0;
      s_we   <= 1'b0;
      s_adr  <= '0;
      s_sel  <= '0;
      s_wdat <= '0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      case (st)
        S_IDLE: begin
          // the response registers block a restart on a strobe not yet dropped
          if (req && !ack && !err) begin
            if (!req_ok) begin
              err <= 1'b1;
            end else begin
              st     <= S_RUN;
              kind_q <= req_kind;
              s_we   <= req_we;
              wdat_q <= req_wdat;
              sel_q  <= req_sel;
              base_q <= req_adr[SAW-1:2];
              pend   <= req_units;
              rdat   <= '0;
              cyc8   <= (req_kind == PORT_B8);
              cyc16  <= (req_kind == PORT_B16);
            end
          end
        end
        S_RUN: begin
          if (stb8 || stb16) begin
            if (s_ack) begin
              stb8      <= 1'b0;
              stb16     <= 1'b0;
              pend[cur] <= 1'b0;
              if (kind_q == PORT_B8) rdat[cur_bofs +: 8]  <= p8_rdat;
              else                   rdat[cur_hofs +: 16] <= p16_rdat;
            end
          end else if (pend == 4'b0000) begin
            ack   <= 1'b1;
            cyc8  <= 1'b0;
            cyc16 <= 1'b0;
            st    <= S_IDLE;
          end else begin
            cur <= nxt;
            if (kind_q == PORT_B8) begin
              stb8   <= 1'b1;
              s_adr  <= {base_q, nxt};
              s_sel  <= 2'b01;
              s_wdat <= {8'h00, wdat_q[nxt_bofs +: 8]};
            end else begin
              stb16  <= 1'b1;
              s_adr  <= {2'b00, base_q[BW-2:0], nxt[0]};
              s_sel  <= sel_q[{nxt[0], 1'b0} +: 2];
              s_wdat <= wdat_q[nxt_hofs +: 16];
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_narrow_bridge.sv
module bus_narrow_bridge
  import bnb_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            SAW      = 10,
  parameter logic [AW-1:0] RMASK    = 32'hF000_0000,
  parameter logic [AW-1:0] B8_BASE  = 32'h6000_0000,
  parameter logic [AW-1:0] B16_BASE = 32'hA000_0000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           m_cyc,
  input  logic           m_stb,
  input  logic           m_we,
  input  logic [AW-1:0]  m_adr,
  input  logic [3:0]     m_sel,
  input  logic [31:0]    m_wdat,
  output logic [31:0]    m_rdat,
  output logic           m_ack,
  output logic           m_err,
  output logic           p8_cyc,
  output logic           p8_stb,
  output logic           p8_we,
  output logic [SAW-1:0] p8_adr,
  output logic [7:0]     p8_wdat,
  input  logic [7:0]     p8_rdat,
  input  logic           p8_ack,
  output logic           p16_cyc,
  output logic           p16_stb,
  output logic           p16_we,
  output logic [SAW-1:0] p16_adr,
  output logic [1:0]     p16_sel,
  output logic [15:0]    p16_wdat,
  input  logic [15:0]    p16_rdat,
  input  logic           p16_ack
);

  port_e          kind;
  logic           ok;
  logic [3:0]     units;
  logic           s_we;
  logic [SAW-1:0] s_adr;
  logic [1:0]     s_sel;
  logic [15:0]    s_wdat;

  bnb_decode #(
    .AW(AW), .RMASK(RMASK), .B8_BASE(B8_BASE), .B16_BASE(B16_BASE)
  ) u_dec (
    .adr(m_adr), .sel(m_sel), .kind(kind), .ok(ok), .units(units)
  );

  bnb_seq #(.SAW(SAW)) u_seq (
    .clk(clk), .rst(rst),
    .req(m_cyc & m_stb), .req_we(m_we), .req_adr(m_adr[SAW-1:0]),
    .req_sel(m_sel), .req_wdat(m_wdat),
    .req_kind(kind), .req_ok(ok), .req_units(units),
    .rdat(m_rdat), .ack(m_ack), .err(m_err),
    .cyc8(p8_cyc), .stb8(p8_stb), .cyc16(p16_cyc), .stb16(p16_stb),
    .s_we(s_we), .s_adr(s_adr), .s_sel(s_sel), .s_wdat(s_wdat),
    .p8_rdat(p8_rdat), .p8_ack(p8_ack),
    .p16_rdat(p16_rdat), .p16_ack(p16_ack)
  );

  assign p8_we    = s_we;
  assign p8_adr   = s_adr;
  assign p8_wdat  = s_wdat[7:0];
  assign p16_we   = s_we;
  assign p16_adr  = s_adr;
  assign p16_sel  = s_sel;
  assign p16_wdat = s_wdat;

endmodule

// File: rtl/bnb_chk.sv
module bnb_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] m_rdat,
  input logic        m_ack,
  input logic        m_err,
  input logic        p8_cyc,
  input logic        p8_stb,
  input logic        p8_ack,
  input logic        p16_cyc,
  input logic        p16_stb,
  input logic        p16_ack
);

  assert_resp_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(m_ack && m_err));

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    m_ack |=> !m_ack);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    m_err |=> !m_err);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    m_ack |-> $stable(m_rdat));

  assert_port_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(p8_cyc && p16_cyc));

  assert_stb_in_cyc_R1: assert property (@(posedge clk) disable iff (rst)
    (!p8_stb || p8_cyc) && (!p16_stb || p16_cyc));

  assert_err_no_slave_R6: assert property (@(posedge clk) disable iff (rst)
    m_err |-> (!p8_cyc && !p16_cyc));

  assert_gap8_R10: assert property (@(posedge clk) disable iff (rst)
    (p8_stb && p8_ack) |=> !p8_stb);

  assert_gap16_R10: assert property (@(posedge clk) disable iff (rst)
    (p16_stb && p16_ack) |=> !p16_stb);

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!p8_cyc && !p8_stb && !p16_cyc && !p16_stb && !m_ack && !m_err));

endmodule

bind bus_narrow_bridge bnb_chk u_chk (
  .clk(clk), .rst(rst), .m_rdat(m_rdat), .m_ack(m_ack), .m_err(m_err),
  .p8_cyc(p8_cyc), .p8_stb(p8_stb), .p8_ack(p8_ack),
  .p16_cyc(p16_cyc), .p16_stb(p16_stb), .p16_ack(p16_ack)
);

// File: tb/tb_bus_narrow_bridge.sv
`timescale 1ns/1ps
module tb_bus_narrow_bridge;

  localparam int SAW = 10;
  localparam int DEPTH = 1 << SAW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic           m_cyc = 0, m_stb = 0, m_we = 0;
  logic [31:0]    m_adr = '0;
  logic [3:0]     m_sel = '0;
  logic [31:0]    m_wdat = '0;
  logic [31:0]    m_rdat;
  logic           m_ack, m_err;
  logic           p8_cyc, p8_stb, p8_we;
  logic [SAW-1:0] p8_adr;
  logic [7:0]     p8_wdat, p8_rdat;
  logic           p8_ack;
  logic           p16_cyc, p16_stb, p16_we;
  logic [SAW-1:0] p16_adr;
  logic [1:0]     p16_sel;
  logic [15:0]    p16_wdat, p16_rdat;
  logic           p16_ack;

  bus_narrow_bridge #(.SAW(SAW)) dut (.*);

  int n_checks = 0;
  int n_fail   = 0;

  // ---------------- slave models ----------------
  logic [7:0]  mem8  [DEPTH];
  logic [15:0] mem16 [DEPTH];
  logic [7:0]  ref8  [DEPTH];
  logic [15:0] ref16 [DEPTH];
  int          slog[$];   // {we,port,sel,adr}

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem8[i]  = 8'(i * 7 + 3);
      ref8[i]  = 8'(i * 7 + 3);
      mem16[i] = 16'(i * 291 + 16'h1357);
      ref16[i] = 16'(i * 291 + 16'h1357);
    end
  end

  initial begin p8_ack = 0; p8_rdat = 0; p16_ack = 0; p16_rdat = 0; end

  always @(posedge clk) begin
    if (p8_stb && !p8_ack) begin
      p8_ack  <= 1'b1;
      p8_rdat <= mem8[p8_adr];
      if (p8_we) mem8[p8_adr] <= p8_wdat;
      slog.push_back((int'(p8_we) << 16) | (1 << 14) | (1 << 12) | int'(p8_adr));
    end else p8_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (p16_stb && !p16_ack) begin
      p16_ack  <= 1'b1;
      p16_rdat <= mem16[p16_adr];
      if (p16_we && p16_sel[0]) mem16[p16_adr][7:0]  <= p16_wdat[7:0];
      if (p16_we && p16_sel[1]) mem16[p16_adr][15:8] <= p16_wdat[15:8];
      slog.push_back((int'(p16_we) << 16) | (2 << 14) | (int'(p16_sel) << 12) | int'(p16_adr));
    end else p16_ack <= 1'b0;
  end

  // ---------------- per-clock protocol monitor ----------------
  int  mon_fail = 0;
  bit  prev8 = 0, prev16 = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (m_ack && m_err) mon_fail++;
      if (p8_cyc && p16_cyc) mon_fail++;
      if (prev8 && p8_stb) mon_fail++;
      if (prev16 && p16_stb) mon_fail++;
    end
    prev8  = p8_stb && p8_ack;
    prev16 = p16_stb && p16_ack;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [31:0] a);
    if (a[31:28] == 4'h6) return 1;
    if (a[31:28] == 4'hA) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] ref_byte(input int kind, input logic [31:0] a, input int k);
    logic [SAW-1:0] ix;
    if (kind == 1) begin
      ix = {a[SAW-1:2], 2'(k)};
      return ref8[ix];
    end
    ix = {2'b00, a[SAW-2:2], 1'(k >> 1)};
    return (k % 2 == 1) ? ref16[ix][15:8] : ref16[ix][7:0];
  endfunction

  // one master access, checked against the requirements
  task automatic run(input bit we, input logic [31:0] a, input logic [3:0] s,
                     input logic [31:0] wd, input string req);
    int kind = kind_of(a);
    bit legal = (kind != 0) && (s != 4'b0000) &&
                !(kind == 2 && s[1] && s[2] && !(s[0] && s[3]));
    int exp_q[$];
    int t = 0;
    bit got_ack, got_err;
    logic [31:0] rd;
    if (legal && kind == 1)
      for (int k = 0; k < 4; k++)
        if (s[k]) exp_q.push_back((int'(we) << 16) | (1 << 14) | (1 << 12) |
                                  int'({a[SAW-1:2], 2'(k)}));
    if (legal && kind == 2)
      for (int h = 0; h < 2; h++)
        if (s[2*h] || s[2*h+1])
          exp_q.push_back((int'(we) << 16) | (2 << 14) | (int'(s[2*h +: 2]) << 12) |
                          int'({2'b00, a[SAW-2:2], 1'(h)}));
    @(negedge clk);
    slog.delete();
    m_cyc = 1; m_stb = 1; m_we = we; m_adr = a; m_sel = s; m_wdat = wd;
    while (!(m_ack || m_err) && t < 200) begin
      @(negedge clk);
      t++;
    end
    got_ack = m_ack; got_err = m_err; rd = m_rdat;
    m_cyc = 0; m_stb = 0;
    chk(t < 200, req, "response timeout", 32'(t), 32'd200);
    @(negedge clk);
    chk(!m_ack && !m_err, "R8", "response longer than one clock",
        {30'd0, m_ack, m_err}, 32'd0);
    chk(got_ack == legal && got_err == !legal, req, "ack/err",
        {30'd0, got_ack, got_err}, {30'd0, legal, !legal});
    chk(slog.size() == exp_q.size(), req, "slave cycle count",
        32'(slog.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < slog.size(); i++)
      chk(slog[i] == exp_q[i], req, "slave cycle {we,port,sel,adr}",
          32'(slog[i]), 32'(exp_q[i]));
    if (legal && we) begin
      for (int k = 0; k < 4; k++) if (s[k]) begin
        if (kind == 1) ref8[{a[SAW-1:2], 2'(k)}] = wd[8*k +: 8];
        else if (k % 2 == 1) ref16[{2'b00, a[SAW-2:2], 1'(k >> 1)}][15:8] = wd[8*k +: 8];
        else ref16[{2'b00, a[SAW-2:2], 1'(k >> 1)}][7:0] = wd[8*k +: 8];
      end
    end
    if (legal && !we)
      for (int k = 0; k < 4; k++) if (s[k])
        chk(rd[8*k +: 8] == ref_byte(kind, a, k), req, $sformatf("read lane %0d", k),
            32'(rd[8*k +: 8]), 32'(ref_byte(kind, a, k)));
  endtask

  // watchdog
  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!p8_cyc && !p8_stb && !p16_cyc && !p16_stb && !m_ack && !m_err, "R9",
        "idle after reset", {26'd0, p8_cyc, p8_stb, p16_cyc, p16_stb, m_ack, m_err}, 32'd0);

    // R1 R2: byte port, full words
    for (int w = 0; w < 4; w++) run(0, 32'h6000_0000 + 32'(4*w), 4'hF, 0, "R2");
    run(1, 32'h6000_0010, 4'hF, 32'habba_beef, "R2");
    run(1, 32'h6000_0014, 4'hF, 32'h1a2b_3c4d, "R2");
    run(0, 32'h6000_0010, 4'hF, 0, "R2");
    run(0, 32'h6000_0014, 4'hF, 0, "R2");

    // R4: single lanes on the byte port, others unchanged
    for (int k = 0; k < 4; k++) begin
      run(1, 32'h6000_0010, 4'(1 << k), 32'h4455_6677 + 32'(k), "R4");
      run(0, 32'h6000_0010, 4'hF, 0, "R4");
    end

    // R5: half selects on the byte port
    run(1, 32'h6000_0020, 4'b0011, 32'hdead_0ab1, "R5");
    run(1, 32'h6000_0024, 4'b1100, 32'h2cd3_beef, "R5");
    run(0, 32'h6000_0020, 4'hF, 0, "R5");
    run(0, 32'h6000_0024, 4'b1100, 0, "R5");

    // R6: straddling patterns are legal on the byte port
    run(1, 32'h6000_0028, 4'b0110, 32'h00ba_ad00, "R6");
    run(0, 32'h6000_0028, 4'hF, 0, "R6");

    // R1 R3: half-word port, full words
    for (int w = 0; w < 4; w++) run(0, 32'hA000_0000 + 32'(4*w), 4'hF, 0, "R3");
    run(1, 32'hA000_0010, 4'hF, 32'hcafe_1a7e, "R3");
    run(1, 32'hA000_0014, 4'hF, 32'h5a5a_0f0f, "R3");
    run(0, 32'hA000_0010, 4'hF, 0, "R3");
    run(0, 32'hA000_0014, 4'hF, 0, "R3");

    // R4 R5 on the half-word port
    for (int k = 0; k < 4; k++) begin
      run(1, 32'hA000_0018, 4'(1 << k), 32'h1122_3344 ^ 32'(k * 32'h0101_0101), "R4");
      run(0, 32'hA000_0018, 4'hF, 0, "R4");
    end
    run(1, 32'hA000_001c, 4'b0011, 32'hxxxx_4ef5, "R5");
    run(1, 32'hA000_001c, 4'b1100, 32'h0f0f_0000, "R5");
    run(0, 32'hA000_001c, 4'hF, 0, "R5");
    run(0, 32'hA000_001c, 4'b0011, 0, "R5");

    // R6: straddle rejected on the half-word port, memory untouched
    run(1, 32'hA000_0020, 4'b0110, 32'h00ba_ad00, "R6");
    run(1, 32'hA000_0020, 4'b0111, 32'h11ba_ad22, "R6");
    run(0, 32'hA000_0020, 4'b1110, 0, "R6");
    run(0, 32'hA000_0020, 4'hF, 0, "R6");

    // R7: empty select
    run(1, 32'h6000_0030, 4'b0000, 32'hffff_ffff, "R7");
    run(0, 32'hA000_0030, 4'b0000, 0, "R7");
    run(0, 32'h6000_0030, 4'hF, 0, "R7");

    // R1: unmapped region
    run(1, 32'h0000_0010, 4'hF, 32'h1234_5678, "R1");
    run(0, 32'h2000_0004, 4'b0001, 0, "R1");

    // R8: back-to-back accesses after an error
    run(0, 32'hA000_0014, 4'hF, 0, "R8");

    repeat (4) @(negedge clk);
    chk(mon_fail == 0, "R10", "per-clock strobe/response monitor violations",
        32'(mon_fail), 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule